// File: doc/BRIEF.md
# Switch Forwarding Decision Engine

This block decides where each frame goes in a small Ethernet switch that has a number of LAN ports plus one CPU port. The CPU port carries the highest port index. For every request it takes the ingress port, the destination address and the source address. It searches a small, fully associative address table for the destination. It then applies port-group isolation and per-port blocking. The result is a registered port bitmap, in which bit i stands for port i, together with a discard flag.

Each port belongs to one of a set of port groups. Ports in different groups never exchange frames. Each group can hold one router address. A frame sent to the router address of its own group always goes to the CPU port. The table learns source addresses from ports whose learning is not disabled. When the table is full, a parameter selects the policy: either replace entries in round-robin order, or stop learning.

Top module: `fwd_engine`

## Requirements
- R1: A decision appears on `dec_valid`/`dec_ports`/`dec_drop` on the clock edge after `req_valid`. With no request, `dec_valid`, `dec_ports` and `dec_drop` are 0. Reset clears the outputs and empties the address table.
- R2: A unicast destination (bit 40 of the address is 0) that hits a table entry whose port differs from the ingress port, and lies in the same group, is sent to that single port only.
- R3: A destination that hits an entry holding the ingress port itself is discarded: `dec_drop`=1 and `dec_ports`=0.
- R4: A table hit on a port in a different group from the ingress port is discarded.
- R5: An unknown unicast destination, or any destination with bit 40 set (multicast or broadcast), floods to every port in the ingress port's group except the ingress port.
- R6: A destination equal to the router address of the ingress port's group is sent to the CPU port only (bit NUM_LAN), but only while that group's enable bit is set. A router address that belongs to another group, or whose enable bit is clear, gets normal handling.
- R7: When the ingress port's learn-disable bit is 0 and the source address is unicast, the source is entered in the table with the ingress port, or an existing entry is moved to that port. The new entry is visible to the next request. A port with its learn-disable bit set teaches nothing.
- R8: With REPL_RR=1 a full table replaces entries in round-robin order, starting from entry 0. Free entries are filled lowest index first.
- R9: A blocked ingress port discards every frame whose destination set is anything other than the CPU port alone. A blocked port is removed from every output bitmap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per frame |
| req_port | input | 3 | Ingress port index |
| req_da | input | 48 | Destination address |
| req_sa | input | 48 | Source address |
| cfg_grp | input | 18 | Group index per port, 3 bits each, port 0 lowest |
| cfg_rtr_mac | input | 336 | Router address per group, 48 bits each, group 0 lowest |
| cfg_rtr_en | input | 7 | Router address enable per group |
| cfg_learn_dis | input | 6 | Learning disable per port |
| cfg_block | input | 6 | Blocking state per port |
| dec_valid | output | 1 | Decision valid |
| dec_ports | output | 6 | Destination bitmap, bit i = port i |
| dec_drop | output | 1 | Frame discarded |

## Verification
The bench builds the block with five LAN ports, seven groups, round-robin replacement and a table of only four entries. The small table fills after four learned stations, which puts eviction order, eviction of an address that is still being looked up, and a station moving to another port within a few dozen requests. Two groups with one router address each, the CPU placed in the first group, and one learn-disabled port bring cross-group hits, routing to a CPU outside the ingress group, and router addresses of other groups within reach.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
   localparam int MAC_W  = 48;
   localparam int IG_BIT = 40;   // individual/group bit of the first octet

   function automatic logic is_group_addr(input logic [MAC_W-1:0] a);
      return a[IG_BIT];
   endfunction
endpackage

// File: rtl/fwd_addr_table.sv
module fwd_addr_table
   import fwd_pkg::*;
#(
   parameter int DEPTH   = 8,
   parameter int PW      = 3,
   parameter int REPL_RR = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [MAC_W-1:0] lk_mac,
   output logic             lk_hit,
   output logic [PW-1:0]    lk_port,
   input  logic             lr_en,
   input  logic [MAC_W-1:0] lr_mac,
   input  logic [PW-1:0]    lr_port
);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [DEPTH-1:0] vld_q;
   logic [MAC_W-1:0] mac_q [DEPTH];
   logic [PW-1:0]    prt_q [DEPTH];

   logic [DEPTH-1:0] lk_match, sa_match;
   logic             sa_hit, has_free, full_ok, wr_en;
   logic [IDX_W-1:0] sa_idx, free_idx, full_idx, wr_idx;

   always_comb begin
      lk_port  = '0;
      sa_idx   = '0;
      free_idx = '0;
      for (int i = 0; i < DEPTH; i++) begin
         lk_match[i] = vld_q[i] && (mac_q[i] == lk_mac);
         sa_match[i] = vld_q[i] && (mac_q[i] == lr_mac);
         if (lk_match[i]) lk_port = lk_port | prt_q[i];
      end
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (sa_match[i]) sa_idx = IDX_W'(i);
         if (!vld_q[i])   free_idx = IDX_W'(i);
      end
   end

   assign lk_hit   = |lk_match;
   assign sa_hit   = |sa_match;
   assign has_free = ~&vld_q;

   generate
      if (REPL_RR != 0) begin : g_rr
         logic [IDX_W-1:0] rr_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               rr_q <= '0;
            else if (lr_en && !sa_hit && !has_free)
               rr_q <= (rr_q == IDX_W'(DEPTH - 1)) ? '0 : rr_q + 1'b1;
         end
         assign full_ok  = 1'b1;
         assign full_idx = rr_q;
      end else begin : g_keep
         assign full_ok  = 1'b0;
         assign full_idx = '0;
      end
   endgenerate

   assign wr_en  = lr_en && (sa_hit || has_free || full_ok);
   assign wr_idx = sa_hit ? sa_idx : (has_free ? free_idx : full_idx);

   always_ff @(posedge clk) begin
      if (!rst_n)
         vld_q <= '0;
      else if (wr_en)
         vld_q[wr_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mac_q[wr_idx] <= lr_mac;
         prt_q[wr_idx] <= lr_port;
      end
   end

   // R7: learning updates in place, so an address never sits in two entries
   p_single_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match));
endmodule

// File: rtl/fwd_vlan_map.sv
module fwd_vlan_map
   import fwd_pkg::*;
#(
   parameter int NPORT   = 6,
   parameter int NUM_GRP = 7,
   parameter int PW      = 3,
   parameter int GW      = 3
) (
   input  logic [NPORT*GW-1:0]      cfg_grp,
   input  logic [NUM_GRP*MAC_W-1:0] cfg_rtr_mac,
   input  logic [NUM_GRP-1:0]       cfg_rtr_en,
   input  logic [PW-1:0]            in_port,
   input  logic [MAC_W-1:0]         da,
   output logic [NPORT-1:0]         members,
   output logic                     rtr_hit
);
   logic [GW-1:0] in_grp;

   always_comb begin
      in_grp = '0;
      for (int p = 0; p < NPORT; p++)
         if (in_port == PW'(p)) in_grp = cfg_grp[p*GW +: GW];
   end

   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_mem
         assign members[p] = (cfg_grp[p*GW +: GW] == in_grp);
      end
   endgenerate

   always_comb begin
      rtr_hit = 1'b0;
      for (int g = 0; g < NUM_GRP; g++)
         if (in_grp == GW'(g) && cfg_rtr_en[g] &&
             cfg_rtr_mac[g*MAC_W +: MAC_W] == da)
            rtr_hit = 1'b1;
   end
endmodule

// File: rtl/fwd_engine.sv
module fwd_engine
   import fwd_pkg::*;
#(
   parameter int NUM_LAN   = 5,
   parameter int TBL_DEPTH = 8,
   parameter int NUM_GRP   = 7,
   parameter int REPL_RR   = 1,
   localparam int NPORT    = NUM_LAN + 1,
   localparam int PW       = $clog2(NPORT),
   localparam int GW       = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic [PW-1:0]            req_port,
   input  logic [MAC_W-1:0]         req_da,
   input  logic [MAC_W-1:0]         req_sa,
   input  logic [NPORT*GW-1:0]      cfg_grp,
   input  logic [NUM_GRP*MAC_W-1:0] cfg_rtr_mac,
   input  logic [NUM_GRP-1:0]       cfg_rtr_en,
   input  logic [NPORT-1:0]         cfg_learn_dis,
   input  logic [NPORT-1:0]         cfg_block,
   output logic                     dec_valid,
   output logic [NPORT-1:0]         dec_ports,
   output logic                     dec_drop
);
   localparam int CPU_IDX = NUM_LAN;
   localparam logic [NPORT-1:0] CPU_BIT = NPORT'(1) << CPU_IDX;

   generate
      if (NUM_LAN < 1 || TBL_DEPTH < 2 || NUM_GRP < 1) begin : g_bad_cfg
         $error("fwd_engine: NUM_LAN>=1, TBL_DEPTH>=2, NUM_GRP>=1 required");
      end
   endgenerate

   logic [NPORT-1:0] in_bit, members, raw, pass, fwd;
   logic             lk_hit, rtr_hit, lr_en, blk_in;
   logic [PW-1:0]    lk_port;

   assign in_bit = NPORT'(1) << req_port;
   assign blk_in = |(cfg_block & in_bit);
   assign lr_en  = req_valid && !is_group_addr(req_sa) && !(|(cfg_learn_dis & in_bit));

   fwd_addr_table #(.DEPTH(TBL_DEPTH), .PW(PW), .REPL_RR(REPL_RR)) u_tbl (
      .clk(clk), .rst_n(rst_n),
      .lk_mac(req_da), .lk_hit(lk_hit), .lk_port(lk_port),
      .lr_en(lr_en), .lr_mac(req_sa), .lr_port(req_port)
   );

   fwd_vlan_map #(.NPORT(NPORT), .NUM_GRP(NUM_GRP), .PW(PW), .GW(GW)) u_map (
      .cfg_grp(cfg_grp), .cfg_rtr_mac(cfg_rtr_mac), .cfg_rtr_en(cfg_rtr_en),
      .in_port(req_port), .da(req_da), .members(members), .rtr_hit(rtr_hit)
   );

   always_comb begin
      if (rtr_hit)
         raw = CPU_BIT & ~in_bit;
      else if (!is_group_addr(req_da) && lk_hit)
         raw = (NPORT'(1) << lk_port) & members & ~in_bit;
      else
         raw = members & ~in_bit;
      pass = (blk_in && raw != CPU_BIT) ? '0 : raw;
      fwd  = pass & ~cfg_block;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid <= 1'b0;
         dec_ports <= '0;
         dec_drop  <= 1'b0;
      end else begin
         dec_valid <= req_valid;
         dec_ports <= req_valid ? fwd : '0;
         dec_drop  <= req_valid && (fwd == '0);
      end
   end

   p_valid_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> dec_valid);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!dec_valid && dec_ports == '0 && !dec_drop));
   p_no_reflect_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> ((dec_ports & (NPORT'(1) << $past(req_port))) == '0));
   p_group_fence_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !rtr_hit) |=> ((dec_ports & ~$past(members)) == '0));
   p_router_cpu_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && rtr_hit) |=> ((dec_ports & ~CPU_BIT) == '0));
   p_block_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> ((dec_ports & $past(cfg_block)) == '0));
   p_blocked_in_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && blk_in) |=> (dec_ports == '0 || dec_ports == CPU_BIT));
endmodule

// File: tb/fwd_engine_tb.sv
module fwd_engine_tb;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [15:0] tag;
      logic [2:0]  port;
      logic [47:0] da;
      logic [47:0] sa;
      logic [5:0]  exp;
   } vec_t;

   localparam logic [47:0] MA  = 48'h0000_0000_000A;
   localparam logic [47:0] MB  = 48'h0000_0000_000B;
   localparam logic [47:0] MC  = 48'h0000_0000_000C;
   localparam logic [47:0] MD  = 48'h0000_0000_000D;
   localparam logic [47:0] ME  = 48'h0000_0000_000E;
   localparam logic [47:0] MF  = 48'h0000_0000_000F;
   localparam logic [47:0] MG  = 48'h0000_0000_0010;
   localparam logic [47:0] MZ  = 48'h0000_0000_0077;
   localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
   localparam logic [47:0] RT1 = 48'h0200_0000_0011;
   localparam logic [47:0] RT2 = 48'h0200_0000_0022;

   // groups: ports 0,1,2 and CPU (5) in group 1; ports 3,4 in group 2; table depth 4
   localparam int NV = 17;
   localparam vec_t VEC [NV] = '{
      '{"R5", 3'd0, MB,  MA, 6'b100110},  // unknown, A learned at 0
      '{"R2", 3'd1, MA,  MB, 6'b000001},  // hit port 0
      '{"R3", 3'd0, MA,  MA, 6'b000000},  // hit on ingress
      '{"R4", 3'd3, MA,  MC, 6'b000000},  // hit in other group
      '{"R2", 3'd4, MC,  MD, 6'b001000},  // port 4 learns nothing
      '{"R7", 3'd3, MD,  MC, 6'b010000},  // D unknown: learn-disable held
      '{"R6", 3'd3, RT2, MC, 6'b100000},  // own group router
      '{"R6", 3'd0, RT2, MA, 6'b100110},  // other group router: flood
      '{"R5", 3'd1, BC,  MB, 6'b100101},  // broadcast
      '{"R2", 3'd5, MB,  ME, 6'b000010},  // from CPU, table now full
      '{"R8", 3'd2, ME,  MF, 6'b100000},  // F evicts entry 0 (A)
      '{"R8", 3'd1, MA,  MB, 6'b100101},  // A gone
      '{"R8", 3'd1, MF,  MB, 6'b000100},  // F present
      '{"R8", 3'd2, MB,  MA, 6'b000010},  // B found, then evicted by A
      '{"R8", 3'd0, MA,  MG, 6'b000100},  // A at 2, G evicts C
      '{"R7", 3'd1, MZ,  MA, 6'b100101},  // A moves to port 1
      '{"R7", 3'd0, MA,  MG, 6'b000010}   // A now at port 1
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [2:0]   req_port = '0;
   logic [47:0]  req_da = '0, req_sa = '0;
   logic [17:0]  cfg_grp;
   logic [335:0] cfg_rtr_mac;
   logic [6:0]   cfg_rtr_en;
   logic [5:0]   cfg_learn_dis, cfg_block;
   logic         dec_valid, dec_drop;
   logic [5:0]   dec_ports;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fwd_engine #(.NUM_LAN(5), .TBL_DEPTH(4), .NUM_GRP(7), .REPL_RR(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
      .req_da(req_da), .req_sa(req_sa), .cfg_grp(cfg_grp),
      .cfg_rtr_mac(cfg_rtr_mac), .cfg_rtr_en(cfg_rtr_en),
      .cfg_learn_dis(cfg_learn_dis), .cfg_block(cfg_block),
      .dec_valid(dec_valid), .dec_ports(dec_ports), .dec_drop(dec_drop)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send_chk(input string tag, input logic [2:0] p, input logic [47:0] da,
                           input logic [47:0] sa, input logic [5:0] exp);
      @(negedge clk);
      req_valid = 1'b1; req_port = p; req_da = da; req_sa = sa;
      @(negedge clk);
      req_valid = 1'b0;
      chk({tag, " valid"}, 32'(dec_valid), 32'd1);
      chk({tag, " ports"}, 32'(dec_ports), 32'(exp));
      chk({tag, " drop"},  32'(dec_drop),  32'(exp == 6'b0));
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog R1 actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      cfg_grp       = {3'd1, 3'd2, 3'd2, 3'd1, 3'd1, 3'd1};
      cfg_rtr_mac   = '0;
      cfg_rtr_mac[1*48 +: 48] = RT1;
      cfg_rtr_mac[2*48 +: 48] = RT2;
      cfg_rtr_en    = 7'b0000110;
      cfg_learn_dis = 6'b010000;
      cfg_block     = 6'b000000;

      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 reset valid", 32'(dec_valid), 32'd0);
      chk("R1 reset ports", 32'(dec_ports), 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++)
         send_chk(string'(VEC[i].tag), VEC[i].port, VEC[i].da, VEC[i].sa, VEC[i].exp);

      // R1: idle cycle after a decision
      @(negedge clk);
      chk("R1 idle valid", 32'(dec_valid), 32'd0);
      chk("R1 idle drop",  32'(dec_drop),  32'd0);

      // R9: port 1 blocked
      cfg_block = 6'b000010;
      send_chk("R9 flood minus blocked", 3'd0, BC,  MG, 6'b100100);
      send_chk("R9 blocked ingress",     3'd1, BC,  MA, 6'b000000);
      send_chk("R9 blocked to cpu",      3'd1, RT1, MA, 6'b100000);
      send_chk("R9 hit on blocked",      3'd0, MA,  MG, 6'b000000);
      cfg_block = 6'b000000;

      // R6: disabled router address handled as ordinary unicast
      cfg_rtr_en = 7'b0000010;
      send_chk("R6 router disabled", 3'd3, RT2, MC, 6'b010000);

      // R1: reset empties the table
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 mid reset valid", 32'(dec_valid), 32'd0);
      rst_n = 1'b1;
      send_chk("R1 table cleared", 3'd1, MA, MB, 6'b100101);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule